// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps through a microprogram held in an on-chip control store and issues one microinstruction per clock. A control address register names the microword being issued, and a control buffer register holds that word after a synchronous read. Each microword takes one of two forms, chosen by its most significant bit. A control word drives its control-signal field out to the datapath. A branch word drives no control signals and only steers the sequencer.

On each clock the sequencer works out the next address from the word held in the buffer. A control word always steps to the following address. A branch word can jump without a condition, jump when the zero flag or carry flag is set, or dispatch to the routine of the current instruction opcode. The control store is filled at start-up with a small test microprogram: a fetch routine at address 0, then one short routine for each nonzero opcode, each with room for 16 microwords.

Top module: `useq_sequencer`

## Requirements
- R1: Each clock issues one microword. `car_out` is the address of the word in the control buffer, and `ctrl_out` belongs to that same word.
- R2: A synchronous active-high `rst` sets `car_out` to 0 on the next clock and loads the word at address 0, which is the start of the fetch routine.
- R3: If the buffered word has bit 23 clear (control format), the next address is `car_out + 1`.
- R4: A branch word has bit 23 set, a mode in bits 9:8 and a target in bits 7:0. For mode 00 the next address is the target, with no condition.
- R5: For mode 01 the next address is the target if `flag_zero` is 1, and `car_out + 1` if it is 0.
- R6: For mode 10 the next address is the target if `flag_carry` is 1, and `car_out + 1` if it is 0.
- R7: For mode 11 the next address is `opcode` shifted left by 4, so each opcode's routine starts at a multiple of 16. Opcode 0 maps back to the fetch routine at address 0.
- R8: Sequential stepping from address 255 wraps to address 0.
- R9: `ctrl_out` equals bits 22:0 of a control-format word and is all zero while a branch word is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode of the current machine instruction, used for dispatch |
| flag_zero | input | 1 | Zero flag from the ALU |
| flag_carry | input | 1 | Carry flag from the ALU |
| ctrl_out | output | 23 | Control-signal field of the issued microword |
| car_out | output | 8 | Control address register |

## Verification
The bound checker checks every clock that the address moves correctly after each kind of buffered word: increment, unconditional jump, jump on zero or carry flag, and opcode dispatch. It also checks that control outputs stay zero during branch words and that reset returns the address to 0. Only the bench's scenarios can show that whole routines run in the right order for every opcode and flag combination. The bench also shows the wrap from 255 to 0 along the longest carry path, and that a reset in the middle of a routine leads back into fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CA_W   = 8;
    localparam int UW_W   = 24;
    localparam int OP_W   = 4;
    localparam int CS_W   = UW_W - 1;
    localparam int ROUT_SH = 4;
    localparam int DEPTH  = 1 << CA_W;

    typedef enum logic [1:0] {
        BR_ALWAYS   = 2'b00,
        BR_ZERO     = 2'b01,
        BR_CARRY    = 2'b10,
        BR_DISPATCH = 2'b11
    } br_mode_e;

    typedef struct packed {
        logic             fmt;
        logic [12:0]      spare;
        br_mode_e         mode;
        logic [CA_W-1:0]  target;
    } br_word_t;

    typedef struct packed {
        logic             is_branch;
        br_mode_e         mode;
        logic [CA_W-1:0]  target;
        logic [CS_W-1:0]  signals;
    } uop_t;

    function automatic logic [UW_W-1:0] mk_ctrl(logic [CS_W-1:0] s);
        return {1'b0, s};
    endfunction

    function automatic logic [UW_W-1:0] mk_br(br_mode_e m, logic [CA_W-1:0] t);
        br_word_t b;
        b.fmt    = 1'b1;
        b.spare  = '0;
        b.mode   = m;
        b.target = t;
        return b;
    endfunction

    // Test microprogram: fetch at 0..2, one routine per nonzero opcode.
    function automatic logic [UW_W-1:0] boot_word(int unsigned a);
        int unsigned k;
        int unsigned off;
        logic [CA_W-1:0] base;
        logic [UW_W-1:0] w;
        k    = a >> ROUT_SH;
        off  = a & ((1 << ROUT_SH) - 1);
        base = CA_W'(k << ROUT_SH);
        w    = mk_ctrl(CS_W'(23'h100000 | a));
        if (a == 0) begin
            w = mk_ctrl(CS_W'(1));
        end else if (a == 1) begin
            w = mk_ctrl(CS_W'(2));
        end else if (a == 2) begin
            w = mk_br(BR_DISPATCH, '0);
        end else if (k != 0) begin
            case (off)
                0: w = mk_ctrl(CS_W'((k << 8) | 32'h10));
                1: w = mk_br(BR_ZERO, base + CA_W'(4));
                2: w = mk_ctrl(CS_W'((k << 8) | 32'h20));
                3: w = mk_br(BR_ALWAYS, '0);
                4: w = mk_br(BR_CARRY, base + CA_W'(8));
                5: w = mk_br(BR_ALWAYS, '0);
                8: w = mk_ctrl(CS_W'((k << 8) | 32'h40));
                9: if (k != 15) w = mk_br(BR_ALWAYS, '0);
                default: ;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
    import useq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int DW = UW_W
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    initial begin
        for (int i = 0; i < N; i++) mem[i] = DW'(boot_word(i));
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [UW_W-1:0] word,
    output uop_t            uop
);
    br_word_t b;

    always_comb begin
        b             = br_word_t'(word);
        uop.is_branch = b.fmt;
        uop.mode      = b.mode;
        uop.target    = b.target;
        uop.signals   = b.fmt ? '0 : word[CS_W-1:0];
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int OW = OP_W,
    parameter int SH = ROUT_SH
) (
    input  uop_t          uop,
    input  logic [AW-1:0] car,
    input  logic [OW-1:0] opcode,
    input  logic          flag_zero,
    input  logic          flag_carry,
    output logic [AW-1:0] next_addr
);
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] map_addr;
    logic          take;

    always_comb begin
        seq_addr = car + AW'(1);
        map_addr = AW'({opcode, {SH{1'b0}}});
        take     = 1'b0;
        unique case (uop.mode)
            BR_ALWAYS:   take = 1'b1;
            BR_ZERO:     take = flag_zero;
            BR_CARRY:    take = flag_carry;
            BR_DISPATCH: take = 1'b1;
        endcase
        if (!uop.is_branch)              next_addr = seq_addr;
        else if (uop.mode == BR_DISPATCH) next_addr = map_addr;
        else if (take)                   next_addr = uop.target;
        else                             next_addr = seq_addr;
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int DW = UW_W,
    parameter int OW = OP_W,
    parameter int SW = CS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] opcode,
    input  logic          flag_zero,
    input  logic          flag_carry,
    output logic [SW-1:0] ctrl_out,
    output logic [AW-1:0] car_out
);
    logic [AW-1:0] car_q;
    logic [AW-1:0] nxt;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] cbr_q;
    uop_t          uop;

    assign rd_addr = rst ? '0 : nxt;

    useq_ctrl_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (cbr_q)
    );

    useq_decode u_dec (
        .word (cbr_q),
        .uop  (uop)
    );

    useq_next_addr #(.AW(AW), .OW(OW), .SH(ROUT_SH)) u_nxt (
        .uop        (uop),
        .car        (car_q),
        .opcode     (opcode),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .next_addr  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) car_q <= '0;
        else     car_q <= nxt;
    end

    assign ctrl_out = uop.signals;
    assign car_out  = car_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
    import useq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic            flag_zero,
    input logic            flag_carry,
    input logic [CS_W-1:0] ctrl,
    input logic [CA_W-1:0] car,
    input logic [UW_W-1:0] word
);
    logic [CA_W-1:0] car_inc;
    logic [CA_W-1:0] disp;
    br_word_t        bw;

    assign car_inc = car + CA_W'(1);
    assign disp    = CA_W'({opcode, {ROUT_SH{1'b0}}});
    assign bw      = br_word_t'(word);

    assert_reset_home_R2: assert property (@(posedge clk)
        rst |=> car == '0);

    assert_ctrl_step_R3: assert property (@(posedge clk) disable iff (rst)
        !bw.fmt |=> car == $past(car_inc));

    assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_ALWAYS) |=> car == $past(bw.target));

    assert_zero_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_ZERO && flag_zero) |=> car == $past(bw.target));

    assert_zero_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_ZERO && !flag_zero) |=> car == $past(car_inc));

    assert_carry_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_CARRY && flag_carry) |=> car == $past(bw.target));

    assert_carry_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_CARRY && !flag_carry) |=> car == $past(car_inc));

    assert_dispatch_R7: assert property (@(posedge clk) disable iff (rst)
        (bw.fmt && bw.mode == BR_DISPATCH) |=> car == $past(disp));

    assert_branch_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        bw.fmt |-> ctrl == '0);
endmodule

bind useq_sequencer useq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .ctrl       (ctrl_out),
    .car        (car_out),
    .word       (cbr_q)
);

// File: tb/sim_useq_sequencer.sv
module sim_useq_sequencer;
    import useq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = '0;
    logic        flag_zero = 1'b0;
    logic        flag_carry = 1'b0;
    logic [22:0] ctrl_out;
    logic [7:0]  car_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int    m_car = 0;
    string m_tag = "R2";

    always #4 clk = ~clk;

    useq_sequencer u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .flag_zero(flag_zero), .flag_carry(flag_carry),
        .ctrl_out(ctrl_out), .car_out(car_out)
    );

    // Behavioural reference: address state plus the microprogram as data.
    always @(posedge clk) begin
        logic [23:0] w;
        int m;
        int t;
        w = boot_word(m_car);
        m = (w >> 8) & 3;
        t = w & 255;
        if (rst) begin
            m_car = 0; m_tag = "R2";
        end else if (w[23] == 1'b0) begin
            m_tag = (m_car == 255) ? "R8" : "R3";
            m_car = (m_car + 1) % 256;
        end else if (m == 0) begin
            m_car = t; m_tag = "R4";
        end else if (m == 1) begin
            m_car = flag_zero ? t : (m_car + 1) % 256; m_tag = "R5";
        end else if (m == 2) begin
            m_car = flag_carry ? t : (m_car + 1) % 256; m_tag = "R6";
        end else begin
            m_car = opcode * 16; m_tag = "R7";
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_now();
        logic [23:0] w;
        w = boot_word(m_car);
        check(m_tag, int'(car_out), m_car);
        if (w[23]) check("R9", int'(ctrl_out), 0);
        else       check("R1", int'(ctrl_out), int'(w[22:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2", int'(car_out), 0);
        check("R2", int'(ctrl_out), 1);
        rst = 1'b0;
        for (int fz = 0; fz < 4; fz++) begin
            for (int op = 0; op < 16; op++) begin
                opcode     = 4'(op);
                flag_zero  = fz[0];
                flag_carry = fz[1];
                for (int c = 0; c < 24; c++) begin
                    @(negedge clk);
                    compare_now();
                end
            end
        end
        // Reset in the middle of a routine, then resume into fetch
        opcode = 4'd9; flag_zero = 1'b1; flag_carry = 1'b0;
        repeat (6) begin @(negedge clk); compare_now(); end
        rst = 1'b1;
        @(negedge clk);
        check("R2", int'(car_out), 0);
        rst = 1'b0;
        repeat (40) begin @(negedge clk); compare_now(); end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule